// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits between five interrupt sources and a CPU core. The sources are two external request pins, two timer overflow strobes and one serial-port flag. The block latches a flag for each source and masks it with a per-source enable and a single global enable. It sorts the surviving flags into a high and a low priority class from a per-source priority bit. It then presents one registered request to the CPU, with a vector index and the priority class of that request.

The CPU answers with a one-cycle acknowledge pulse when it takes the vector and a one-cycle return pulse when the service routine ends. The block keeps one in-service bit per priority class. A high-class request may interrupt a low-class routine. No request interrupts a routine of its own class or of a higher class.

Each external pin can be level-sensitive or edge-sensitive. A level-sensitive external pin that is enabled also drives a combinational wake output, so a controller with its clock stopped can still be woken.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_req` is 0, both in-service bits are 0, and both configuration registers read 0.
- R2: A write with `cfg_sel`=0 loads the enable register. Its bit 7 is the global enable, and bits 0 to 4 enable external 0, timer 0, external 1, timer 1 and serial in that order. Bits 6 and 5 always read 0. A write with `cfg_sel`=1 loads the priority register, where bit n (1 = high class) belongs to the same source as enable bit n, and bits 7 to 5 read 0.
- R3: While the global enable is 0, `irq_req` stays 0 whatever the individual enables are. A flag that is still pending is requested once the global enable is set.
- R4: A source whose own enable bit is 0 never produces a request.
- R5: A timer overflow strobe sampled at clock edge k sets that source's flag at edge k. The flag is polled at the next edge, so `irq_req` rises after edge k+1.
- R6: Vector indices are 0 for external 0, 1 for timer 0, 2 for external 1, 3 for timer 1 and 4 for serial. Simultaneous requests in the same class are served in that index order, lowest first.
- R7: When requests of both classes are pending, the high-class one is presented, with `irq_lvl`=1.
- R8: An acknowledge while `irq_req` is 1 sets the in-service bit of `irq_lvl` (`svc_lvl[1]` high, `svc_lvl[0]` low). While low is in service, only high-class requests are presented. While high is in service, nothing is presented.
- R9: A return pulse clears the high in-service bit if it is set, and otherwise clears the low one.
- R10: In edge mode, an external flag is set by a 0-to-1 change of the pin and cleared by acknowledge of its vector. A pin held high does not request again.
- R11: In level mode, an external flag follows the pin one edge later and is not cleared by acknowledge.
- R12: The serial flag follows `ser_flag` and is not cleared by acknowledge.
- R13: `wake` is the combinational OR, over both external pins, of pin high, level mode and source enabled, gated by the global enable. It needs no clock edge.
- R14: An acknowledge while `irq_req` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the enable register, 1 selects the priority register |
| cfg_wdata | input | 8 | Configuration write data |
| ie_view | output | 8 | Enable register contents |
| ip_view | output | 8 | Priority register contents |
| ext_pin | input | 2 | External request pins, active high |
| ext_edge | input | 2 | Per-pin trigger mode, 1 = edge, 0 = level |
| tmr_ovf | input | 2 | Timer overflow strobes |
| ser_flag | input | 1 | Serial receive/transmit flag |
| irq_ack | input | 1 | CPU vector-taken pulse |
| irq_reti | input | 1 | CPU return-from-routine pulse |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 3 | Vector index of the request |
| irq_lvl | output | 1 | Class of the request, 1 = high |
| svc_lvl | output | 2 | In-service bits, [1] high, [0] low |
| wake | output | 1 | Combinational wake request |

## Verification
The hardest state to reach is the one where both in-service bits are set at the same time while new requests are pending in both classes. The return pulses must then unwind in the right order.

The stimulus reaches this state one step at a time. A low-class timer request is acknowledged first. That timer is then struck again, so a same-class request is left waiting. A high-class timer then preempts the routine, is acknowledged and is struck again while it is in service.

Each return pulse is then checked against the in-service bits and against the request that must reappear. The high-class re-request has to appear while the low routine is still open. The waiting low-class request has to appear only after the last return.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC     = 5;
  localparam int NUM_PAIR = 2;
  localparam int VEC_W    = $clog2(NSRC);
  localparam int SER_IDX  = NSRC - 1;
  localparam int REG_W    = 8;
  localparam int GLB_BIT  = REG_W - 1;

  typedef enum logic [VEC_W-1:0] {
    SRC_X0  = 3'd0,
    SRC_T0  = 3'd1,
    SRC_X1  = 3'd2,
    SRC_T1  = 3'd3,
    SRC_SER = 3'd4
  } src_e;

  function automatic logic [VEC_W-1:0] first_set(input logic [NSRC-1:0] m);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (m[i]) r = VEC_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PAIR-1:0]  ext_pin,
  input  logic [NUM_PAIR-1:0]  ext_edge,
  input  logic [NUM_PAIR-1:0]  tmr_ovf,
  input  logic                 ser_flag,
  input  logic                 clr_en,
  input  logic [VEC_W-1:0]     clr_vec,
  output logic [NSRC-1:0]      flags
);

  for (genvar g = 0; g < NUM_PAIR; g++) begin : g_pair
    localparam int XB = 2 * g;
    localparam int TB = 2 * g + 1;
    logic pin_q, xflag_q, tflag_q;
    logic xclr, tclr, rise;

    assign xclr = clr_en && (clr_vec == VEC_W'(XB));
    assign tclr = clr_en && (clr_vec == VEC_W'(TB));
    assign rise = ext_pin[g] && !pin_q;

    // external source: level follows pin, edge latches a rising change
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_q   <= 1'b0;
        xflag_q <= 1'b0;
      end else begin
        pin_q <= ext_pin[g];
        if (!ext_edge[g])  xflag_q <= ext_pin[g];
        else if (rise)     xflag_q <= 1'b1;
        else if (xclr)     xflag_q <= 1'b0;
      end
    end

    // timer source: set by strobe, cleared when its vector is taken
    always_ff @(posedge clk) begin
      if (rst)          tflag_q <= 1'b0;
      else if (tmr_ovf[g]) tflag_q <= 1'b1;
      else if (tclr)    tflag_q <= 1'b0;
    end

    assign flags[XB] = xflag_q;
    assign flags[TB] = tflag_q;

    p_level_follows_r11: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(ext_edge[g])) |-> (xflag_q == $past(ext_pin[g])));

    p_ovf_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
      ($past(tmr_ovf[g]) && !$past(rst)) |-> tflag_q);
  end

  logic sflag_q;
  always_ff @(posedge clk) begin
    if (rst) sflag_q <= 1'b0;
    else     sflag_q <= ser_flag;
  end
  assign flags[SER_IDX] = sflag_q;

endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   flags,
  input  logic [NSRC-1:0]   src_en,
  input  logic              glb_en,
  input  logic [NSRC-1:0]   src_hi,
  input  logic [1:0]        svc_nxt,
  output logic              req_q,
  output logic [VEC_W-1:0]  vec_q,
  output logic              lvl_q
);

  logic [NSRC-1:0]  elig, hi_m, lo_m;
  logic             req_d, lvl_d;
  logic [VEC_W-1:0] vec_d;

  assign elig = flags & src_en & {NSRC{glb_en}};
  assign hi_m = elig & src_hi;
  assign lo_m = elig & ~src_hi;

  always_comb begin
    req_d = 1'b0;
    vec_d = '0;
    lvl_d = 1'b0;
    if ((|hi_m) && !svc_nxt[1]) begin
      req_d = 1'b1;
      vec_d = first_set(hi_m);
      lvl_d = 1'b1;
    end else if ((|lo_m) && (svc_nxt == 2'b00)) begin
      req_d = 1'b1;
      vec_d = first_set(lo_m);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      req_q <= req_d;
      vec_q <= vec_d;
      lvl_q <= lvl_d;
    end
  end

  p_vec_legal_r6: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (vec_q < VEC_W'(NSRC)));

  p_global_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !$past(glb_en)) |-> !req_q);

endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  logic       take_lvl,
  input  logic       reti,
  output logic [1:0] svc_q,
  output logic [1:0] svc_nxt
);

  always_comb begin
    svc_nxt = svc_q;
    if (reti) begin
      if (svc_q[1]) svc_nxt[1] = 1'b0;
      else          svc_nxt[0] = 1'b0;
    end
    if (take) svc_nxt[take_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) svc_q <= 2'b00;
    else     svc_q <= svc_nxt;
  end

  p_reti_pops_r9: assert property (@(posedge clk) disable iff (rst)
    (reti && !take && (svc_q != 2'b00)) |=>
      ($countones(svc_q) == $countones($past(svc_q)) - 1));

  p_take_marks_r8: assert property (@(posedge clk) disable iff (rst)
    (take && !take_lvl) |=> svc_q[0]);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       ie_view,
  output logic [7:0]       ip_view,
  input  logic [1:0]       ext_pin,
  input  logic [1:0]       ext_edge,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_flag,
  input  logic             irq_ack,
  input  logic             irq_reti,
  output logic             irq_req,
  output logic [2:0]       irq_vec,
  output logic             irq_lvl,
  output logic [1:0]       svc_lvl,
  output logic             wake
);

  logic [NSRC-1:0] ie_src_q, ip_q;
  logic            glb_q;
  logic [NSRC-1:0] flags;
  logic [1:0]      svc_nxt;
  logic            take;
  logic [NUM_PAIR-1:0] wake_m;

  // configuration registers; unimplemented bits are never stored
  always_ff @(posedge clk) begin
    if (rst) begin
      ie_src_q <= '0;
      glb_q    <= 1'b0;
      ip_q     <= '0;
    end else if (cfg_we) begin
      if (!cfg_sel) begin
        ie_src_q <= cfg_wdata[NSRC-1:0];
        glb_q    <= cfg_wdata[GLB_BIT];
      end else begin
        ip_q <= cfg_wdata[NSRC-1:0];
      end
    end
  end

  assign ie_view = {glb_q, {(REG_W-1-NSRC){1'b0}}, ie_src_q};
  assign ip_view = {{(REG_W-NSRC){1'b0}}, ip_q};

  assign take = irq_ack && irq_req;

  irq_flag_bank u_flags (
    .clk      (clk),
    .rst      (rst),
    .ext_pin  (ext_pin),
    .ext_edge (ext_edge),
    .tmr_ovf  (tmr_ovf),
    .ser_flag (ser_flag),
    .clr_en   (take),
    .clr_vec  (irq_vec),
    .flags    (flags)
  );

  irq_level_track u_track (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .take_lvl (irq_lvl),
    .reti     (irq_reti),
    .svc_q    (svc_lvl),
    .svc_nxt  (svc_nxt)
  );

  irq_select u_sel (
    .clk     (clk),
    .rst     (rst),
    .flags   (flags),
    .src_en  (ie_src_q),
    .glb_en  (glb_q),
    .src_hi  (ip_q),
    .svc_nxt (svc_nxt),
    .req_q   (irq_req),
    .vec_q   (irq_vec),
    .lvl_q   (irq_lvl)
  );

  // wake path is purely combinational so it works with the clock stopped
  for (genvar g = 0; g < NUM_PAIR; g++) begin : g_wake
    assign wake_m[g] = ext_pin[g] && !ext_edge[g] && ie_src_q[2*g];
  end
  assign wake = glb_q && (|wake_m);

  p_high_blocks_all_r8: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> !svc_lvl[1]);

  p_low_blocks_low_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_lvl) |-> !svc_lvl[0]);

endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_we, cfg_sel;
  logic [7:0] cfg_wdata;
  logic [7:0] ie_view, ip_view;
  logic [1:0] ext_pin, ext_edge, tmr_ovf;
  logic       ser_flag, irq_ack, irq_reti;
  logic       irq_req, irq_lvl, wake;
  logic [2:0] irq_vec;
  logic [1:0] svc_lvl;

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct packed {
    logic       req;
    logic [2:0] vec;
    logic       lvl;
    logic [1:0] svc;
  } exp_t;
  exp_t  sbq[$];
  string tagq[$];
  exp_t  cur;
  string cur_tag;

  always #4 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ie_view(ie_view), .ip_view(ip_view),
    .ext_pin(ext_pin), .ext_edge(ext_edge), .tmr_ovf(tmr_ovf),
    .ser_flag(ser_flag), .irq_ack(irq_ack), .irq_reti(irq_reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
    .svc_lvl(svc_lvl), .wake(wake)
  );

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      cur     = sbq.pop_front();
      cur_tag = tagq.pop_front();
      n_chk++;
      if (irq_req !== cur.req || svc_lvl !== cur.svc ||
          (cur.req && (irq_vec !== cur.vec || irq_lvl !== cur.lvl))) begin
        n_fail++;
        $display("FAIL %s: req=%0b vec=%0d lvl=%0b svc=%b expected req=%0b vec=%0d lvl=%0b svc=%b",
                 cur_tag, irq_req, irq_vec, irq_lvl, svc_lvl,
                 cur.req, cur.vec, cur.lvl, cur.svc);
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_o(logic r, logic [2:0] v, logic l, logic [1:0] s, string tag);
    sbq.push_back('{req: r, vec: v, lvl: l, svc: s});
    tagq.push_back(tag);
    step();
  endtask

  task automatic chk8(logic [7:0] got, logic [7:0] exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    ext_pin = '0; ext_edge = '0; tmr_ovf = '0;
    ser_flag = 1'b0; irq_ack = 1'b0; irq_reti = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_tmr(int i);
    tmr_ovf[i] = 1'b1;
    step();
    tmr_ovf[i] = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
  endtask

  task automatic reti();
    irq_reti = 1'b1; step(); irq_reti = 1'b0;
  endtask

  initial begin
    // R1 reset state
    do_reset();
    expect_o(0, 0, 0, 2'b00, "R1 reset outputs");
    chk8(ie_view, 8'h00, "R1 enable reg");
    chk8(ip_view, 8'h00, "R1 priority reg");

    // R2 register layout
    wr(0, 8'hFF);
    chk8(ie_view, 8'h9F, "R2 enable reserved bits");
    wr(1, 8'hFF);
    chk8(ip_view, 8'h1F, "R2 priority reserved bits");

    // R3 global enable off
    do_reset();
    wr(0, 8'h1F);
    pulse_tmr(0); step(); step();
    expect_o(0, 0, 0, 2'b00, "R3 global off blocks");
    wr(0, 8'h9F); step();
    expect_o(1, 1, 0, 2'b00, "R3 pending after global on");

    // R4 individual enable
    do_reset();
    wr(0, 8'h88);
    pulse_tmr(0); step(); step();
    expect_o(0, 0, 0, 2'b00, "R4 disabled source");
    pulse_tmr(1); step();
    expect_o(1, 3, 0, 2'b00, "R4 enabled source");

    // R5 poll latency
    do_reset();
    wr(0, 8'h82);
    pulse_tmr(0);
    expect_o(0, 0, 0, 2'b00, "R5 not yet polled");
    expect_o(1, 1, 0, 2'b00, "R5 polled next cycle");

    // R6 same-class order, R12 serial persists
    do_reset();
    wr(0, 8'h9F); wr(1, 8'h00);
    ext_edge = 2'b11; ext_pin = 2'b11; ser_flag = 1'b1; tmr_ovf = 2'b11;
    step(); tmr_ovf = 2'b00; step();
    expect_o(1, 0, 0, 2'b00, "R6 ext0 first");
    for (int v = 1; v <= 4; v++) begin
      ack();
      expect_o(0, 0, 0, 2'b01, "R6 in service");
      reti();
      expect_o(1, 3'(v), 0, 2'b00, "R6 next in order");
    end
    ack(); reti();
    expect_o(1, 4, 0, 2'b00, "R12 serial not cleared");

    // R7 high beats low
    do_reset();
    wr(0, 8'h9F); wr(1, 8'h10);
    ser_flag = 1'b1;
    pulse_tmr(0); step();
    expect_o(1, 4, 1, 2'b00, "R7 high class first");

    // R8 / R9 nesting
    do_reset();
    wr(0, 8'h8A); wr(1, 8'h08);
    pulse_tmr(0); step();
    expect_o(1, 1, 0, 2'b00, "R8 low request");
    ack();
    expect_o(0, 0, 0, 2'b01, "R8 low in service");
    pulse_tmr(0); step();
    expect_o(0, 0, 0, 2'b01, "R8 no same-class preempt");
    pulse_tmr(1); step();
    expect_o(1, 3, 1, 2'b01, "R8 high preempts low");
    ack();
    expect_o(0, 0, 0, 2'b11, "R8 both in service");
    pulse_tmr(1); step();
    expect_o(0, 0, 0, 2'b11, "R8 nothing preempts high");
    reti();
    expect_o(1, 3, 1, 2'b01, "R9 high cleared first");
    ack();
    expect_o(0, 0, 0, 2'b11, "R9 re-entered high");
    reti();
    expect_o(0, 0, 0, 2'b01, "R9 low still open");
    reti();
    expect_o(1, 1, 0, 2'b00, "R9 low cleared");

    // R10 edge mode
    do_reset();
    wr(0, 8'h81);
    ext_edge = 2'b01; ext_pin = 2'b01;
    step(); step();
    expect_o(1, 0, 0, 2'b00, "R10 edge request");
    ack();
    expect_o(0, 0, 0, 2'b01, "R10 acked");
    reti();
    expect_o(0, 0, 0, 2'b00, "R10 no retrigger");
    step();
    expect_o(0, 0, 0, 2'b00, "R10 held pin quiet");
    ext_pin = 2'b00; step(); ext_pin = 2'b01; step(); step();
    expect_o(1, 0, 0, 2'b00, "R10 new edge");

    // R11 level mode
    do_reset();
    wr(0, 8'h84);
    ext_pin = 2'b10;
    step(); step();
    expect_o(1, 2, 0, 2'b00, "R11 level request");
    ack();
    expect_o(0, 0, 0, 2'b01, "R11 acked");
    reti();
    expect_o(1, 2, 0, 2'b00, "R11 not cleared by ack");
    ext_pin = 2'b00; step(); step();
    expect_o(0, 0, 0, 2'b00, "R11 follows pin");

    // R13 wake
    do_reset();
    wr(0, 8'h81);
    chk8({7'd0, wake}, 8'd0, "R13 wake idle");
    ext_pin = 2'b01; #1;
    chk8({7'd0, wake}, 8'd1, "R13 wake level pin");
    ext_edge = 2'b01; #1;
    chk8({7'd0, wake}, 8'd0, "R13 wake edge mode");
    ext_edge = 2'b00;
    wr(0, 8'h01); #1;
    chk8({7'd0, wake}, 8'd0, "R13 wake global off");

    // R14 stray acknowledge
    do_reset();
    wr(0, 8'h82);
    ack();
    expect_o(0, 0, 0, 2'b00, "R14 ack ignored");
    pulse_tmr(0); step();
    expect_o(1, 1, 0, 2'b00, "R14 later request");

    wait (sbq.size() == 0);
    step();
    summary();
  end
endmodule